// File: doc/BRIEF.md
# Dual-Bank One-Time-Programmable Configuration Store

The block holds a 70-bit metering configuration word that can be set three ways: a volatile test load, a permanent burn of individual cells, and a readback that copies the burned cells into the active register. Two identical parameter banks share the word with a bank-select bit and a use-programmed bit. When the use-programmed bit is clear, fixed default settings drive the outputs. The decoded fields of the active bank are presented continuously. These fields are the current-gain code and its numeric gain, the anti-creep select, the motor-pulse select, the calibration-multiplier select, the LED-rate select and the 22-bit pulse level.

Three asynchronous pins carry the serial protocol. `tm_i` frames the operations, `sel_i` is the step clock and a mode qualifier, and `data_i` carries the serial data. All three are synchronised to `clk_i`. Their edges are detected from the synchronised levels, so every pin edge takes effect on the third rising clock edge after it. Programming is possible only if the pins show `tm_i`=1 and `sel_i`=0 when the block leaves reset. Reset stands for power-up and models a blank part: it clears the volatile register and the cell array. During readback the cell contents appear on `cal_o`. At all other times `cal_o` passes `cal_pulse_i` through.

Top module: `otp_cfg_store`

## Requirements
- R1: Word layout. Bit 0 selects programmed values, and bit 1 selects bank 1 (bits 67:35) instead of bank 0 (bits 34:2). Each bank, from its MSB down, holds gain[2], anti-creep[2], motor[2], cal-multiplier[2], LED[3] and pulse level[22]. Bits 69:68 are unused.
- R2: While bit 0 of the active register is 0, the outputs are gain code 11, anti-creep 01, motor 10, cal-multiplier 01, LED 101 and pulse level 0x6A6D4.
- R3: Programming mode is latched once after reset. It is on only if the synchronised `tm_i`=1 and `sel_i`=0 at that point. Otherwise pin activity never changes the outputs, and `cal_o` follows `cal_pulse_i`.
- R4: A `tm_i` fall with `sel_i` low, followed by a `tm_i` rise with `sel_i` low, starts a test load. On each of the next 70 `sel_i` rises, the inverse of `data_i` shifts into the active register at bit 0, so bit 69 is sent first. The 70th rise ends the load.
- R5: Reset restores the default outputs and clears the volatile register and the cells. `prog_mode_o` reads 0 and `cal_o` equals `cal_pulse_i` while in reset.
- R6: A `tm_i` fall with `sel_i` high, followed by a `tm_i` rise with `sel_i` low, enters burn. The first `sel_i` rise selects cell 69, and each later rise selects the next lower cell, stopping at 0. A `tm_i` fall with `sel_i` low sets the selected cell to 1, and a `tm_i` fall with `sel_i` high leaves burn. A cell is never cleared.
- R7: A `tm_i` rise with `sel_i` high starts readback. `cal_o` reads 1 until the first `sel_i` rise. Each `sel_i` rise then shows the inverse of the next cell, starting at cell 69. `tm_i` falls are ignored, and the next `tm_i` rise ends readback.
- R8: Burning does not change the active register. Ending a readback loads the active register with the cell contents. If a `sel_i` rise arrives in the same cycle as the ending `tm_i` rise, the ending takes precedence.
- R9: The numeric gain output decodes codes 00/01/10/11 as 4/16/16/20.
- R10: Every pin edge takes effect on the third rising `clk_i` edge after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-up) |
| tm_i | input | 1 | Mode/framing pin, asynchronous |
| sel_i | input | 1 | Step clock and mode qualifier pin, asynchronous |
| data_i | input | 1 | Serial data pin, asynchronous |
| cal_pulse_i | input | 1 | Calibration pulse to pass through outside readback |
| prog_mode_o | output | 1 | Programming mode latched after reset |
| cal_o | output | 1 | Calibration pulse, or inverted cell data during readback |
| gain_code_o | output | 2 | Active gain code |
| gain_o | output | 5 | Numeric current gain |
| creep_sel_o | output | 2 | Active anti-creep select |
| mtr_sel_o | output | 2 | Active motor pulse-rate select |
| calx_sel_o | output | 2 | Active calibration multiplier select |
| led_sel_o | output | 3 | Active LED pulse-rate select |
| pulse_lev_o | output | 22 | Active pulse level |

## Verification
Two events can land in the same clock cycle. During readback, a `sel_i` rise can coincide with the `tm_i` rise that ends the readback. Similarly, during burn, a step can coincide with the framing fall. The bench provokes the readback case by changing `tm_i` and `sel_i` on the same clock. It then expects `cal_o` to return to pass-through at once and the active register to hold the full cell contents, not a stepped readback value. A behavioural model tracks the expected outputs and is compared with every field of the block on every clock. This comparison catches any off-by-one in the three-stage pin latency or in the cell pointer.

// File: rtl/otp_cfg_pkg.sv
package otp_cfg_pkg;
  localparam int WORD_W    = 70;
  localparam int LEV_W     = 22;
  localparam int FIELD_W   = 2 + 2 + 2 + 2 + 3 + LEV_W;
  localparam int BANK0_LSB = 2;
  localparam int BANK1_LSB = BANK0_LSB + FIELD_W;
  localparam int PTR_W     = $clog2(WORD_W);
  localparam int NPIN      = 3;

  typedef struct packed {
    logic [1:0]       gain;
    logic [1:0]       creep;
    logic [1:0]       mtr;
    logic [1:0]       calx;
    logic [2:0]       led;
    logic [LEV_W-1:0] lev;
  } cfg_t;

  localparam cfg_t DEF_CFG = '{gain: 2'b11, creep: 2'b01, mtr: 2'b10,
                               calx: 2'b01, led: 3'b101, lev: 22'h06A6D4};

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARMED, ST_TWRITE, ST_BURN, ST_READ
  } st_e;
endpackage

// File: rtl/otp_pin_sync.sv
module otp_pin_sync #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] s0_q, s1_q, d_q;

  for (genvar g = 0; g < W; g++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s0_q[g] <= 1'b0;
        s1_q[g] <= 1'b0;
        d_q[g]  <= 1'b0;
      end else begin
        s0_q[g] <= pin_i[g];
        s1_q[g] <= s0_q[g];
        d_q[g]  <= s1_q[g];
      end
    end
    assign rise_o[g] = s1_q[g] & ~d_q[g];
    assign fall_o[g] = ~s1_q[g] & d_q[g];
  end

  assign lvl_o = s1_q;
endmodule

// File: rtl/otp_ctrl.sv
module otp_ctrl
  import otp_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tm_s_i,
  input  logic              tm_rise_i,
  input  logic              tm_fall_i,
  input  logic              sel_s_i,
  input  logic              sel_rise_i,
  input  logic              dat_s_i,
  output logic              prog_mode_o,
  output logic              reading_o,
  output logic              rd_bit_o,
  output logic [WORD_W-1:0] word_o
);
  st_e               state_q;
  logic [1:0]        boot_cnt_q;
  logic              prog_mode_q, fall_sel_q, ptr_vld_q, rd_bit_q;
  logic [PTR_W-1:0]  ptr_q, nxt_ptr;
  logic [PTR_W-1:0]  bit_cnt_q;
  logic [WORD_W-1:0] word_q, fuse_q;
  logic              booted;

  assign booted = (boot_cnt_q == 2'd3);

  // pointer walks from MSB down and parks at 0
  always_comb begin
    if (!ptr_vld_q)         nxt_ptr = PTR_W'(WORD_W - 1);
    else if (ptr_q == '0)   nxt_ptr = '0;
    else                    nxt_ptr = ptr_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      boot_cnt_q  <= '0;
      prog_mode_q <= 1'b0;
      fall_sel_q  <= 1'b0;
      ptr_vld_q   <= 1'b0;
      ptr_q       <= '0;
      bit_cnt_q   <= '0;
      rd_bit_q    <= 1'b1;
      word_q      <= '0;
      fuse_q      <= '0;
    end else if (!booted) begin
      boot_cnt_q <= boot_cnt_q + 1'b1;
      if (boot_cnt_q == 2'd2) begin
        prog_mode_q <= tm_s_i & ~sel_s_i;
        word_q      <= fuse_q;
      end
    end else if (prog_mode_q) begin
      unique case (state_q)
        ST_IDLE: if (tm_fall_i) begin
          fall_sel_q <= sel_s_i;
          state_q    <= ST_ARMED;
        end
        ST_ARMED: if (tm_rise_i) begin
          ptr_vld_q <= 1'b0;
          bit_cnt_q <= '0;
          rd_bit_q  <= 1'b1;
          if (sel_s_i)         state_q <= ST_READ;
          else if (fall_sel_q) state_q <= ST_BURN;
          else                 state_q <= ST_TWRITE;
        end
        ST_TWRITE: if (sel_rise_i) begin
          word_q    <= {word_q[WORD_W-2:0], ~dat_s_i};
          bit_cnt_q <= bit_cnt_q + 1'b1;
          if (bit_cnt_q == PTR_W'(WORD_W - 1)) state_q <= ST_IDLE;
        end
        ST_BURN: begin
          if (sel_rise_i) begin
            ptr_q     <= nxt_ptr;
            ptr_vld_q <= 1'b1;
          end
          if (tm_fall_i) begin
            if (sel_s_i) begin
              fall_sel_q <= 1'b1;
              state_q    <= ST_ARMED;
            end else if (ptr_vld_q) begin
              fuse_q[ptr_q] <= 1'b1;
            end
          end
        end
        ST_READ: begin
          if (tm_rise_i) begin
            word_q  <= fuse_q;
            state_q <= ST_IDLE;
          end else if (sel_rise_i) begin
            ptr_q     <= nxt_ptr;
            ptr_vld_q <= 1'b1;
            rd_bit_q  <= ~fuse_q[nxt_ptr];
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign prog_mode_o = prog_mode_q;
  assign reading_o   = (state_q == ST_READ);
  assign rd_bit_o    = rd_bit_q;
  assign word_o      = word_q;

  AST_MODE_LATCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    booted |=> $stable(prog_mode_q)); // R3
  AST_NORMAL_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (booted && !prog_mode_q) |=> $stable(word_q)); // R3
  AST_FUSE_NO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(fuse_q) & ~fuse_q) == '0)); // R6
  AST_FUSE_ONLY_BURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fuse_q != $past(fuse_q)) |-> ($past(state_q) == ST_BURN)); // R6
  AST_READ_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_READ && $past(state_q) != ST_READ) |-> $past(tm_rise_i && sel_s_i)); // R7
  AST_LOAD_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_cnt_q <= PTR_W'(WORD_W))); // R4
endmodule

// File: rtl/otp_decode.sv
module otp_decode
  import otp_cfg_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output cfg_t              cfg_o,
  output logic [4:0]        gain_o
);
  cfg_t bank;

  always_comb begin
    bank  = word_i[1] ? cfg_t'(word_i[BANK1_LSB +: FIELD_W])
                      : cfg_t'(word_i[BANK0_LSB +: FIELD_W]);
    cfg_o = word_i[0] ? bank : DEF_CFG;
    unique case (cfg_o.gain)
      2'b00:   gain_o = 5'd4;
      2'b11:   gain_o = 5'd20;
      default: gain_o = 5'd16;
    endcase
  end
endmodule

// File: rtl/otp_cfg_store.sv
module otp_cfg_store
  import otp_cfg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tm_i,
  input  logic             sel_i,
  input  logic             data_i,
  input  logic             cal_pulse_i,
  output logic             prog_mode_o,
  output logic             cal_o,
  output logic [1:0]       gain_code_o,
  output logic [4:0]       gain_o,
  output logic [1:0]       creep_sel_o,
  output logic [1:0]       mtr_sel_o,
  output logic [1:0]       calx_sel_o,
  output logic [2:0]       led_sel_o,
  output logic [LEV_W-1:0] pulse_lev_o
);
  logic [NPIN-1:0]   lvl, rise, fall;
  logic              reading, rd_bit;
  logic [WORD_W-1:0] word;
  cfg_t              cfg;

  otp_pin_sync #(.W(NPIN)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  ({data_i, sel_i, tm_i}),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  otp_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tm_s_i      (lvl[0]),
    .tm_rise_i   (rise[0]),
    .tm_fall_i   (fall[0]),
    .sel_s_i     (lvl[1]),
    .sel_rise_i  (rise[1]),
    .dat_s_i     (lvl[2]),
    .prog_mode_o (prog_mode_o),
    .reading_o   (reading),
    .rd_bit_o    (rd_bit),
    .word_o      (word)
  );

  otp_decode u_dec (
    .word_i (word),
    .cfg_o  (cfg),
    .gain_o (gain_o)
  );

  assign cal_o       = reading ? rd_bit : cal_pulse_i;
  assign gain_code_o = cfg.gain;
  assign creep_sel_o = cfg.creep;
  assign mtr_sel_o   = cfg.mtr;
  assign calx_sel_o  = cfg.calx;
  assign led_sel_o   = cfg.led;
  assign pulse_lev_o = cfg.lev;

  AST_PASS_OUTSIDE_PROG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_mode_o |-> (cal_o == cal_pulse_i)); // R3
endmodule

// File: tb/otp_cfg_store_tb_top.sv
module otp_cfg_store_tb_top;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic tm = 1'b0, sel = 1'b0, dat = 1'b0, cal_in = 1'b0;
  logic prog_mode, cal_out;
  logic [1:0] gain_code, creep, mtr, calx;
  logic [4:0] gain;
  logic [2:0] led;
  logic [21:0] lev;

  always #10 clk = ~clk;

  otp_cfg_store dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tm_i(tm), .sel_i(sel), .data_i(dat),
    .cal_pulse_i(cal_in), .prog_mode_o(prog_mode), .cal_o(cal_out),
    .gain_code_o(gain_code), .gain_o(gain), .creep_sel_o(creep),
    .mtr_sel_o(mtr), .calx_sel_o(calx), .led_sel_o(led), .pulse_lev_o(lev)
  );

  int n_run = 0, n_fail = 0;
  bit chk_en = 0;

  // behavioural model
  bit [69:0] m_vol, m_fuse;
  bit m_prog, m_fd, m_pv, m_rd;
  int m_state, m_ptr, m_cnt; // 0 idle 1 armed 2 load 3 burn 4 read

  task automatic chk(string tag, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit [32:0] fld(bit [1:0] g, bit [1:0] c, bit [1:0] m,
                                    bit [1:0] k, bit [2:0] l, bit [21:0] p);
    return {g, c, m, k, l, p};
  endfunction

  function automatic bit [32:0] exp_cfg();
    if (!m_vol[0]) return fld(2'b11, 2'b01, 2'b10, 2'b01, 3'b101, 22'h06A6D4);
    return m_vol[1] ? m_vol[67:35] : m_vol[34:2];
  endfunction

  function automatic int exp_gain(bit [1:0] c);
    return c == 2'b00 ? 4 : (c == 2'b11 ? 20 : 16);
  endfunction

  task automatic compare_all();
    bit [32:0] e = exp_cfg();
    chk("R1 gain", gain_code, e[32:31]);
    chk("R1 creep", creep, e[30:29]);
    chk("R1 motor", mtr, e[28:27]);
    chk("R1 calx", calx, e[26:25]);
    chk("R1 led", led, e[24:22]);
    chk("R1 level", lev, e[21:0]);
    chk("R9 gain value", gain, exp_gain(e[32:31]));
    chk("R3 mode", prog_mode, m_prog);
    chk("R7 cal", cal_out, (m_state == 4) ? m_rd : cal_in);
  endtask

  always @(negedge clk) if (chk_en) compare_all();

  task automatic step_ptr();
    if (!m_pv) m_ptr = 69; else if (m_ptr > 0) m_ptr--;
    m_pv = 1;
  endtask

  task automatic model(bit to, bit tn, bit so, bit sn, bit d);
    bit tr = !to && tn, tf = to && !tn, sr = !so && sn;
    if (!m_prog) return;
    case (m_state)
      0: if (tf) begin m_fd = sn; m_state = 1; end
      1: if (tr) begin
        m_pv = 0; m_cnt = 0; m_rd = 1;
        m_state = sn ? 4 : (m_fd ? 3 : 2);
      end
      2: if (sr) begin
        m_vol = {m_vol[68:0], !d}; m_cnt++;
        if (m_cnt == 70) m_state = 0;
      end
      3: begin
        int cur = m_ptr; bit cv = m_pv;
        if (sr) step_ptr();
        if (tf) begin
          if (sn) begin m_fd = 1; m_state = 1; end
          else if (cv) m_fuse[cur] = 1;
        end
      end
      4: if (tr) begin m_vol = m_fuse; m_state = 0; end
         else if (sr) begin step_ptr(); m_rd = !m_fuse[m_ptr]; end
      default: ;
    endcase
  endtask

  // R10: pins change on a falling edge, model follows at third rising edge
  task automatic drive(bit t, bit s, bit d);
    bit to = tm, so = sel;
    @(negedge clk);
    tm = t; sel = s; dat = d; cal_in = ~cal_in;
    repeat (3) @(posedge clk);
    #1 model(to, t, so, s, d);
    @(posedge clk);
  endtask

  task automatic do_reset(bit t, bit s);
    chk_en = 0;
    @(negedge clk);
    rst_ni = 0; tm = t; sel = s; dat = 0;
    repeat (2) @(negedge clk);
    chk("R5 reset level", lev, 22'h06A6D4);
    chk("R5 reset gain", gain_code, 2'b11);
    chk("R5 reset mode", prog_mode, 0);
    chk("R5 reset cal", cal_out, cal_in);
    m_vol = '0; m_fuse = '0; m_state = 0; m_pv = 0; m_rd = 1; m_ptr = 0; m_cnt = 0;
    rst_ni = 1;
    repeat (3) @(posedge clk);
    #1 m_prog = t && !s; m_vol = m_fuse;
    chk_en = 1;
    @(posedge clk);
  endtask

  task automatic test_load(bit [69:0] w);
    drive(1, 0, 0); drive(0, 0, 0); drive(1, 0, 0);
    for (int i = 69; i >= 0; i--) begin
      drive(1, 0, !w[i]); drive(1, 1, !w[i]);
    end
  endtask

  task automatic burn(bit [69:0] w);
    drive(1, 1, 0); drive(0, 1, 0); drive(0, 0, 0); drive(1, 0, 0);
    for (int i = 69; i >= 0; i--) begin
      drive(1, 1, 0); drive(1, 0, 0);
      if (w[i]) begin drive(0, 0, 0); drive(1, 0, 0); end
    end
    drive(1, 1, 0); drive(0, 1, 0);
  endtask

  task automatic read_back(bit [69:0] cells);
    drive(tm, 1, 0); drive(0, 1, 0); drive(1, 1, 0);
    @(negedge clk) chk("R7 before first step", cal_out, 1);
    for (int i = 69; i >= 0; i--) begin
      drive(1, 0, 0); drive(1, 1, 0);
      @(negedge clk) chk("R7 cell", cal_out, !cells[i]);
    end
    drive(1, 0, 0); drive(0, 0, 0);
    // tm rise and sel rise in one cycle: exit wins
    drive(1, 1, 0);
  endtask

  bit [69:0] w1, w2, w3, w4;

  initial begin
    w1 = {2'b00, 33'h0, fld(2'b00, 2'b10, 2'b11, 2'b00, 3'b110, 22'h012345), 2'b01};
    w2 = {2'b00, fld(2'b01, 2'b11, 2'b00, 2'b10, 3'b011, 22'h03ABCD),
          fld(2'b10, 2'b01, 2'b01, 2'b01, 3'b001, 22'h000111), 2'b11};
    w3 = {2'b00, 33'h0, fld(2'b10, 2'b00, 2'b01, 2'b11, 3'b000, 22'h2AAAAA), 2'b01};
    w4 = {2'b00, fld(2'b11, 2'b01, 2'b10, 2'b01, 3'b100, 22'h155555), 33'h0, 2'b11};

    // normal mode: pins ignored (R3), defaults (R2)
    do_reset(0, 0);
    chk("R2 default level", lev, 22'h06A6D4);
    chk("R2 default led", led, 3'b101);
    test_load(w1);
    @(negedge clk) chk("R3 pins ignored", lev, 22'h06A6D4);

    // programming mode
    do_reset(1, 0);
    chk("R3 prog entered", prog_mode, 1);
    test_load(w1);
    @(negedge clk) chk("R4 bank0 level", lev, 22'h012345);
    chk("R9 gain 4", gain, 4);
    test_load(w2);
    @(negedge clk) chk("R1 bank1 level", lev, 22'h03ABCD);
    chk("R9 gain 16", gain, 16);

    burn(w3);
    @(negedge clk) chk("R8 burn leaves active", lev, 22'h03ABCD);
    read_back(w3);
    @(negedge clk) chk("R8 loaded level", lev, 22'h2AAAAA);
    chk("R8 exit cal passthrough", cal_out, cal_in);

    burn(w4);
    read_back(w3 | w4);
    @(negedge clk) chk("R6 bank1 after second burn", lev, 22'h155555);
    chk("R9 gain 20", gain, 20);

    // reset clears everything (R5); sel high blocks programming (R3)
    do_reset(1, 1);
    chk("R5 cleared level", lev, 22'h06A6D4);
    chk("R3 sel high gives normal", prog_mode, 0);
    test_load(w1);
    @(negedge clk) chk("R3 load ignored", lev, 22'h06A6D4);

    chk_en = 0;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog R10 act=hung exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule